// File: doc/BRIEF.md
# Single-Channel PWM Timer with Lockable Atomic Reload

This block generates one pulse-width modulated output from a free-running counter that is clocked directly by the input clock. Software programs it through a small word-addressed register bus with four 32-bit locations: a counter, a period, a duty and a control word. Period and duty are expressed in input clock ticks, so a time in nanoseconds becomes a count of clock frequency times that time, divided by 1e9.

Writes to period, duty and the duty-polarity bit land in a shadow set. A separate active set drives the waveform. The active set is copied from the shadow set when the output is enabled, and again at each period boundary, but only while the lock bit in control is clear. Software sets lock, rewrites period, duty and polarity, and then clears lock. All three changes then take effect together at the start of the next period and never partway through one.

A three-state machine sequences the channel. `ST_OFF` holds the counter at zero and drives the idle level. `ST_RUN` counts and reloads at each wrap. `ST_HOLD` counts but freezes the active set. The transitions are as follows. Enable takes `ST_OFF` to `ST_RUN` when unlocked, or to `ST_HOLD` when locked. Lock set takes `ST_RUN` to `ST_HOLD`, and lock clear takes `ST_HOLD` back to `ST_RUN`. Enable clear takes either running state to `ST_OFF`.

Top module: `pwm_lockstep`

## Requirements
- R1: After reset, control reads 0x18 (both polarity bits set), counter, period and duty read 0, the machine is off and the output is high.
- R2: The register at byte offset 0x04 is the period shadow, 0x08 the duty shadow and 0x0C control, and each reads back what was last written. Offset 0x00 reads the counter, and writes to it have no effect. Reads are combinational from the address, and writes take effect when valid and write are both high on a clock edge with address bits 1:0 zero.
- R3: While control bit 0 (enable) is clear, the counter is 0 and the output equals control bit 4 (idle polarity, 1 = idle high).
- R4: The edge that samples enable set moves the machine out of off, zeroes the counter and loads the active set from the current shadow values, regardless of lock. After that the counter runs 0 .. period-1 and wraps.
- R5: While running with a non-zero period, the output equals control bit 3 (duty polarity, 1 = active high) when the counter is below duty, and the complement of bit 3 otherwise.
- R6: A duty greater than or equal to the period gives a constant active level. A period of 0 gives a constant non-active level, with the counter at 0.
- R7: While unlocked, new shadow values are adopted only at a period wrap (counter returning to 0), never mid-period.
- R8: While control bit 6 (lock) is set and the channel is running, the active period, duty and polarity do not change, even though the shadow registers accept writes.
- R9: After lock is cleared, the new period, duty and duty polarity all take effect together at the next wrap.
- R10: Control stores bits 0 to 6 and bit 8 (bits 2:1 mode, bit 5 alignment and bit 8 low-power disable are stored only). Bit 7 and bits 31:9 read as 0, so writing all ones reads back 0x17F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; period and duty count its ticks |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (4) | Byte address of the register |
| bus_wdata | input | W (32) | Write data |
| bus_rdata | output | W (32) | Read data for the addressed register |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest situation to reach is the period wrap at which a lock release becomes visible. Period, duty and polarity have been rewritten under lock while the old waveform keeps running, and all three must switch on one edge. The stimulus gets there in several steps. It runs a short period, sets lock mid-period, and rewrites all three values to clearly different ones, including an inverted polarity. It then runs several full old periods and clears lock mid-period. A behavioural model compares output and read data on every cycle, so an early, late or partial switch shows up at the exact cycle it occurs.

// File: rtl/pwm_lockstep_pkg.sv
package pwm_lockstep_pkg;
    localparam int CTRL_W = 9;
    localparam int B_EN   = 0;
    localparam int B_DPOL = 3;
    localparam int B_IPOL = 4;
    localparam int B_LOCK = 6;

    // both polarity bits positive out of reset
    localparam logic [CTRL_W-1:0] CTRL_RST   = 9'h018;
    // bit 7 is not implemented
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 9'h17F;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_PER  = 2'd1,
        SEL_DUTY = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pwm_lockstep_regs.sv
module pwm_lockstep_regs
    import pwm_lockstep_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [AW-1:0]     bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      cnt,
    output logic [W-1:0]      bus_rdata,
    output logic [W-1:0]      per_sh,
    output logic [W-1:0]      duty_sh,
    output logic [CTRL_W-1:0] ctrl
);
    reg_sel_e sel;
    logic     wr_hit;

    assign sel    = reg_sel_e'(bus_addr[3:2]);
    assign wr_hit = bus_valid && bus_write && (bus_addr[1:0] == 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_sh  <= '0;
            duty_sh <= '0;
            ctrl    <= CTRL_RST;
        end else if (wr_hit) begin
            unique case (sel)
                SEL_PER:  per_sh  <= bus_wdata;
                SEL_DUTY: duty_sh <= bus_wdata;
                SEL_CTRL: ctrl    <= bus_wdata[CTRL_W-1:0] & CTRL_WMASK;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CNT:  bus_rdata = cnt;
            SEL_PER:  bus_rdata = per_sh;
            SEL_DUTY: bus_rdata = duty_sh;
            default:  bus_rdata = {{(W-CTRL_W){1'b0}}, ctrl};
        endcase
    end
endmodule

// File: rtl/pwm_lockstep_core.sv
module pwm_lockstep_core
    import pwm_lockstep_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] per_sh,
    input  logic [W-1:0] duty_sh,
    input  logic         dpol_sh,
    input  logic         en,
    input  logic         lock,
    input  logic         ipol,
    output run_state_e   st,
    output logic [W-1:0] cnt,
    output logic [W-1:0] per_act,
    output logic [W-1:0] duty_act,
    output logic         dpol_act,
    output logic         pwm_out
);
    run_state_e st_q, st_d;
    logic       wrap;
    logic       take;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  if (en) st_d = lock ? ST_HOLD : ST_RUN;
            ST_RUN:  if (!en) st_d = ST_OFF; else if (lock) st_d = ST_HOLD;
            ST_HOLD: if (!en) st_d = ST_OFF; else if (!lock) st_d = ST_RUN;
            default: st_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    assign wrap = (per_act == '0) || (cnt == per_act - W'(1));
    // entry load ignores lock; wrap load needs lock clear
    assign take = en && ((st_q == ST_OFF) || (wrap && !lock));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            per_act  <= '0;
            duty_act <= '0;
            dpol_act <= 1'b1;
        end else begin
            if (st_q == ST_OFF || !en || wrap) cnt <= '0;
            else                               cnt <= cnt + W'(1);
            if (take) begin
                per_act  <= per_sh;
                duty_act <= duty_sh;
                dpol_act <= dpol_sh;
            end
        end
    end

    // output process
    always_comb begin
        unique case (st_q)
            ST_OFF:  pwm_out = ipol;
            default: pwm_out = ((per_act != '0) && (cnt < duty_act)) ? dpol_act : ~dpol_act;
        endcase
    end

    assign st = st_q;
endmodule

// File: rtl/pwm_lockstep.sv
module pwm_lockstep
    import pwm_lockstep_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          pwm_out
);
    logic [W-1:0]      per_sh, duty_sh;
    logic [CTRL_W-1:0] ctrl;
    logic [W-1:0]      cnt_q, per_act, duty_act;
    logic              dpol_act;
    logic              ctl_lock;
    run_state_e        run_st;

    assign ctl_lock = ctrl[B_LOCK];

    pwm_lockstep_regs #(.W(W), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt_q),
        .bus_rdata (bus_rdata),
        .per_sh    (per_sh),
        .duty_sh   (duty_sh),
        .ctrl      (ctrl)
    );

    pwm_lockstep_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .per_sh   (per_sh),
        .duty_sh  (duty_sh),
        .dpol_sh  (ctrl[B_DPOL]),
        .en       (ctrl[B_EN]),
        .lock     (ctl_lock),
        .ipol     (ctrl[B_IPOL]),
        .st       (run_st),
        .cnt      (cnt_q),
        .per_act  (per_act),
        .duty_act (duty_act),
        .dpol_act (dpol_act),
        .pwm_out  (pwm_out)
    );
endmodule

// File: rtl/pwm_lockstep_chk.sv
module pwm_lockstep_chk
    import pwm_lockstep_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input run_state_e   st,
    input logic         lock,
    input logic [W-1:0] cnt,
    input logic [W-1:0] per_act,
    input logic [W-1:0] duty_act,
    input logic         dpol_act,
    input logic         pwm_out
);
    a_r3_off_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF) |-> (cnt == '0));

    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OFF && per_act != '0) |-> (cnt < per_act));

    a_r6_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OFF && per_act != '0 && duty_act >= per_act) |-> (pwm_out == dpol_act));

    a_r7_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OFF && $past(st != ST_OFF) && !$stable(per_act)) |-> (cnt == '0));

    a_r8_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OFF && $past(st != ST_OFF) && $past(lock))
            |-> ($stable(per_act) && $stable(duty_act) && $stable(dpol_act)));
endmodule

bind pwm_lockstep pwm_lockstep_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (run_st),
    .lock     (ctl_lock),
    .cnt      (cnt_q),
    .per_act  (per_act),
    .duty_act (duty_act),
    .dpol_act (dpol_act),
    .pwm_out  (pwm_out)
);

// File: tb/pwm_lockstep_test.sv
module pwm_lockstep_test;
    localparam int W  = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic          pwm_out;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    pwm_lockstep #(.W(W), .AW(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // behavioural reference
    int unsigned m_cnt, m_per, m_duty, m_per_sh, m_duty_sh;
    bit          m_dpol, m_run;
    bit [8:0]    m_ctrl;

    function automatic bit exp_out();
        if (!m_run) return m_ctrl[4];
        return (m_per != 0 && m_cnt < m_duty) ? m_dpol : !m_dpol;
    endfunction

    function automatic logic [31:0] exp_rdata();
        case (bus_addr[3:2])
            2'd0:    return m_cnt;
            2'd1:    return m_per_sh;
            2'd2:    return m_duty_sh;
            default: return {23'd0, m_ctrl};
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit [8:0]    oc;
        int unsigned op, od;
        oc = m_ctrl; op = m_per_sh; od = m_duty_sh;
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_duty = 0; m_per_sh = 0; m_duty_sh = 0;
            m_dpol = 1; m_run = 0; m_ctrl = 9'h018;
        end else begin
            if (!m_run) begin
                m_cnt = 0;
                if (oc[0]) begin
                    m_run = 1; m_per = op; m_duty = od; m_dpol = oc[3];
                end
            end else if (!oc[0]) begin
                m_run = 0; m_cnt = 0;
            end else if (m_per == 0 || m_cnt == m_per - 1) begin
                m_cnt = 0;
                if (!oc[6]) begin
                    m_per = op; m_duty = od; m_dpol = oc[3];
                end
            end else begin
                m_cnt++;
            end
            if (bus_valid && bus_write && bus_addr[1:0] == 2'b00) begin
                case (bus_addr[3:2])
                    2'd1:    m_per_sh = bus_wdata;
                    2'd2:    m_duty_sh = bus_wdata;
                    2'd3:    m_ctrl = bus_wdata[8:0] & 9'h17F;
                    default: ;
                endcase
            end
        end
        #2;
        if (rst_n) begin
            check(cur_req, {31'd0, pwm_out}, {31'd0, exp_out()}, "pwm_out vs model");
            check(cur_req, bus_rdata, exp_rdata(), "rdata vs model");
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp, "register read");
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        rd_check("R1", 4'hC, 32'h18);
        rd_check("R1", 4'h0, 32'h0);
        rd_check("R1", 4'h4, 32'h0);
        rd_check("R1", 4'h8, 32'h0);
        check("R1", {31'd0, pwm_out}, 32'd1, "reset output level");

        // R2 register map and ignored counter write
        cur_req = "R2";
        wr(4'h4, 32'd10);
        wr(4'h8, 32'd3);
        rd_check("R2", 4'h4, 32'd10);
        rd_check("R2", 4'h8, 32'd3);
        wr(4'h0, 32'h55);
        rd_check("R2", 4'h0, 32'h0);

        // R3 idle level follows bit 4
        cur_req = "R3";
        wr(4'hC, 32'h100);
        check("R3", {31'd0, pwm_out}, 32'd0, "idle low");
        wr(4'hC, 32'h110);
        check("R3", {31'd0, pwm_out}, 32'd1, "idle high");

        // R4/R5 enable normal polarity, period 10 duty 3
        cur_req = "R4";
        wr(4'hC, 32'h10B);
        idle(12);
        cur_req = "R5";
        idle(20);

        // R7 unlocked mid-period change
        cur_req = "R7";
        wr(4'h8, 32'd7);
        idle(30);

        // R6 full duty, then zero period
        cur_req = "R6";
        wr(4'h8, 32'd12);
        idle(25);
        check("R6", {31'd0, pwm_out}, 32'd1, "full duty active");
        wr(4'h4, 32'd0);
        idle(15);
        check("R6", {31'd0, pwm_out}, 32'd0, "zero period inactive");
        rd_check("R6", 4'h0, 32'd0);
        wr(4'h4, 32'd8);
        wr(4'h8, 32'd2);
        idle(20);

        // R8 lock then rewrite everything
        cur_req = "R8";
        idle(3);
        wr(4'hC, 32'h14B);
        wr(4'h4, 32'd20);
        wr(4'h8, 32'd15);
        wr(4'hC, 32'h153);
        idle(40);

        // R9 unlock: all three at next wrap
        cur_req = "R9";
        idle(2);
        wr(4'hC, 32'h113);
        idle(45);

        // R10 control mask, then disable
        cur_req = "R10";
        wr(4'hC, 32'hFFFF_FFFF);
        rd_check("R10", 4'hC, 32'h17F);
        idle(10);
        cur_req = "R3";
        wr(4'hC, 32'h0);
        rd_check("R3", 4'h0, 32'h0);
        check("R3", {31'd0, pwm_out}, 32'd0, "disabled level");
        idle(5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule